// File: doc/BRIEF.md
# Signal-Free Time Scheduler

This block decides the moment at which a transmitter may place a start bit on a single-wire, open-drain consumer-control bus. Before any node may drive the bus, the line must have been released for a minimum idle window. The scheduler counts that window on a 32 kHz kernel tick, in units of half a nominal data-bit period. The nominal data-bit period is 2.4 ms, so one half period is 1.2 ms, which is 39 ticks by default.

The window has two sources. In automatic mode it depends on how this node's own last transmission ended. A node whose last attempt failed waits the shortest time. A node that has just succeeded waits the longest. A node with no recent history waits in between. In fixed mode, software picks one of seven windows. Counting can begin in two ways. It can start when the transmit request appears. It can also be pre-counted from bus events, so that a request made later launches in the same cycle. Any low level on the line while the window is counted cancels the count, and counting restarts once the line is released again.

The scheduler sits between the request logic and the bit-level transmitter. Its only output is a one-cycle "start allowed" strobe.

Top module: `sft_sched`

## Requirements
- R1: After reset, and in any cycle following a cycle with `enable` low, `start_ok` is 0.
- R2: With `sel_code` = k, where k is 1 to 7, the window is (2k-1) half periods, that is (2k-1)*HALF_TICKS qualified ticks. `start_ok` rises in the cycle after the edge that registers the last tick of the window.
- R3: With `sel_code` = 0 and history "new initiator", the window is 8 half periods.
- R4: With `sel_code` = 0, after a `tx_won` pulse, the window is 12 half periods.
- R5: With `sel_code` = 0, after a `tx_lost` pulse, the window is 5 half periods.
- R6: With `auto_pre` = 0, bus events do not start a count. Counting begins only once `tx_req` is seen in the idle state, and the full window then elapses before `start_ok`.
- R7: With `auto_pre` = 1, any bit of `evt` restarts the count from zero. If the window has already elapsed, raising `tx_req` gives `start_ok` in the same cycle. If the count is still running, the request waits for the full window.
- R8: A cycle with `line_hi` = 0 during counting or after the window has elapsed clears the count. The cycle after such a low cycle has `start_ok` = 0. The full window is counted again after the line returns high.
- R9: `start_ok` is high for exactly one cycle per window. After a launch, no new window is counted until a bus event arrives.
- R10: Deasserting `enable` returns the history to "new initiator".

State machine: OFF (disabled) goes to IDLE when `auto_pre` = 0, or to COUNT when `auto_pre` = 1. IDLE goes to COUNT on a request when the line is high, or to HOLD when the line is low. With `auto_pre` = 1, IDLE also goes to COUNT on an event. HOLD goes to COUNT when the line is high. COUNT goes to HOLD when the line is low, and to READY when the window is done. With `auto_pre` = 1, an event in COUNT restarts the count. READY goes to HOLD when the line is low. With `auto_pre` = 1, an event in READY goes back to COUNT. READY goes to SENT on a request, which raises the strobe. SENT goes to COUNT on an event when `auto_pre` = 1, or to IDLE on an event when `auto_pre` = 0. Any state goes to OFF when `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low clears the state and the history |
| tick | input | 1 | One-cycle 32 kHz kernel tick qualifier |
| auto_pre | input | 1 | 1: count starts on bus events; 0: count starts on request |
| sel_code | input | 3 | 0: window from history; 1-7: fixed window of (2k-1) half periods |
| tx_req | input | 1 | Transmit request level |
| line_hi | input | 1 | Synchronised bus level, 1 = released |
| evt | input | EVT_W | Bus-event pulses: end of message, transmit error, missing acknowledge, underrun, receive abort, end of error bit |
| tx_won | input | 1 | Pulse: this node's last transmission succeeded |
| tx_lost | input | 1 | Pulse: this node's last transmission failed |
| start_ok | output | 1 | One-cycle strobe: start bit may be driven |

## Verification
The window counter registers a tick on each rising edge. The state moves to READY on the same edge that registers the last tick, and `start_ok` is decoded combinationally from that state. The strobe is therefore due in the low phase directly after the edge of the final tick. The bench drives one tick per cycle and samples at every falling edge, so the tick index at which the strobe first appears is the measured window, and it is compared with the expected value for the selected code and history. Each event pulse and each return of the line takes one edge, and leaving IDLE on a request takes one more. The bench therefore inserts two tick-free cycles before counting starts, so that no tick is lost. For the zero-latency case, the bench checks the strobe in the same cycle in which it raises `tx_req`, and it checks that the strobe is gone one edge later.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_IDLE  = 3'd1,
        S_HOLD  = 3'd2,
        S_COUNT = 3'd3,
        S_READY = 3'd4,
        S_SENT  = 3'd5
    } sft_state_e;

    typedef enum logic [1:0] {
        H_NEW  = 2'd0,
        H_WON  = 2'd1,
        H_LOST = 2'd2
    } sft_hist_e;

    // Window length in half data-bit periods
    function automatic logic [3:0] win_halves(input logic [2:0] sel, input sft_hist_e h);
        logic [3:0] r;
        if (sel != 3'd0) begin
            r = {sel, 1'b0} - 4'd1;
        end else begin
            unique case (h)
                H_WON:   r = 4'd12;
                H_LOST:  r = 4'd5;
                default: r = 4'd8;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sft_history.sv
module sft_history
    import sft_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      tx_won,
    input  logic      tx_lost,
    output sft_hist_e hist
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= H_NEW;
        end else if (!enable) begin
            hist <= H_NEW;
        end else if (tx_lost) begin
            hist <= H_LOST;
        end else if (tx_won) begin
            hist <= H_WON;
        end
    end

endmodule

// File: rtl/sft_window.sv
module sft_window
    import sft_pkg::*;
#(
    parameter int HALF_TICKS = 39,
    parameter int CW         = 9
) (
    input  logic [2:0]    sel_code,
    input  sft_hist_e     hist,
    output logic [CW-1:0] limit
);

    logic [3:0] halves;

    always_comb begin
        halves = win_halves(sel_code, hist);
        limit  = CW'(halves) * CW'(HALF_TICKS);
    end

endmodule

// File: rtl/sft_counter.sv
module sft_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = run && (cnt_q == limit - CW'(1));

endmodule

// File: rtl/sft_sched.sv
module sft_sched
    import sft_pkg::*;
#(
    parameter int HALF_TICKS = 39,
    parameter int EVT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             auto_pre,
    input  logic [2:0]       sel_code,
    input  logic             tx_req,
    input  logic             line_hi,
    input  logic [EVT_W-1:0] evt,
    input  logic             tx_won,
    input  logic             tx_lost,
    output logic             start_ok
);

    localparam int MAX_TICKS = 13 * HALF_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    sft_state_e    state_q, state_d;
    sft_hist_e     hist;
    logic [CW-1:0] limit;
    logic          cnt_clr, cnt_run, cnt_done;
    logic          evt_any, pre_evt;

    assign evt_any = |evt;
    assign pre_evt = auto_pre && evt_any;
    assign cnt_run = tick && line_hi && (state_q == S_COUNT);

    sft_history u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tx_won  (tx_won),
        .tx_lost (tx_lost),
        .hist    (hist)
    );

    sft_window #(.HALF_TICKS(HALF_TICKS), .CW(CW)) u_win (
        .sel_code (sel_code),
        .hist     (hist),
        .limit    (limit)
    );

    sft_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .limit (limit),
        .done  (cnt_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        if (!enable) begin
            state_d = S_OFF;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                S_OFF: begin
                    state_d = auto_pre ? S_COUNT : S_IDLE;
                    cnt_clr = 1'b1;
                end
                S_IDLE: begin
                    if (pre_evt) begin
                        state_d = S_COUNT;
                        cnt_clr = 1'b1;
                    end else if (!auto_pre && tx_req) begin
                        state_d = line_hi ? S_COUNT : S_HOLD;
                        cnt_clr = 1'b1;
                    end
                end
                S_HOLD: begin
                    cnt_clr = 1'b1;
                    if (line_hi) state_d = S_COUNT;
                end
                S_COUNT: begin
                    if (!line_hi) begin
                        state_d = S_HOLD;
                        cnt_clr = 1'b1;
                    end else if (pre_evt) begin
                        cnt_clr = 1'b1;
                    end else if (cnt_done) begin
                        state_d = S_READY;
                    end
                end
                S_READY: begin
                    if (!line_hi) begin
                        state_d = S_HOLD;
                        cnt_clr = 1'b1;
                    end else if (pre_evt) begin
                        state_d = S_COUNT;
                        cnt_clr = 1'b1;
                    end else if (tx_req) begin
                        state_d = S_SENT;
                    end
                end
                S_SENT: begin
                    if (evt_any) begin
                        state_d = auto_pre ? S_COUNT : S_IDLE;
                        cnt_clr = 1'b1;
                    end
                end
                default: begin
                    state_d = S_OFF;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        start_ok = enable && (state_q == S_READY) && line_hi && tx_req && !pre_evt;
    end

endmodule

// File: rtl/sft_sched_chk.sv
module sft_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       auto_pre,
    input logic       tx_req,
    input logic       line_hi,
    input logic       start_ok,
    input logic [2:0] state,
    input logic [1:0] hist,
    input logic       cnt_done,
    input logic       evt_any
);

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !start_ok);

    // R9
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !start_ok);

    // R8
    line_low_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_hi |=> !start_ok);

    // R10
    hist_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (hist == 2'(sft_pkg::H_NEW)));

    // R2
    window_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_done && !evt_any && enable) |=> (state == 3'(sft_pkg::S_READY)));

    // R6
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !auto_pre && !tx_req && state == 3'(sft_pkg::S_IDLE))
        |=> (state != 3'(sft_pkg::S_COUNT)));

endmodule

bind sft_sched sft_sched_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .auto_pre (auto_pre),
    .tx_req   (tx_req),
    .line_hi  (line_hi),
    .start_ok (start_ok),
    .state    (state_q),
    .hist     (hist),
    .cnt_done (cnt_done),
    .evt_any  (evt_any)
);

// File: tb/sft_sched_tb.sv
module sft_sched_tb_top;

    localparam int HT    = 39;
    localparam int EVT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             tick = 1'b0;
    logic             auto_pre = 1'b0;
    logic [2:0]       sel_code = 3'd0;
    logic             tx_req = 1'b0;
    logic             line_hi = 1'b1;
    logic [EVT_W-1:0] evt = '0;
    logic             tx_won = 1'b0;
    logic             tx_lost = 1'b0;
    logic             start_ok;

    int checks = 0;
    int fails  = 0;
    int mh     = 0;   // bench history model: 0 new, 1 won, 2 lost
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    sft_sched #(.HALF_TICKS(HT), .EVT_W(EVT_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick     (tick),
        .auto_pre (auto_pre),
        .sel_code (sel_code),
        .tx_req   (tx_req),
        .line_hi  (line_hi),
        .evt      (evt),
        .tx_won   (tx_won),
        .tx_lost  (tx_lost),
        .start_ok (start_ok)
    );

    function automatic int exp_ticks(input int sel, input int h);
        int halves;
        if (sel != 0) halves = 2 * sel - 1;
        else if (h == 1) halves = 12;
        else if (h == 2) halves = 5;
        else halves = 8;
        return halves * HT;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        tick = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Ticks every cycle until start_ok appears; then confirms single-cycle strobe
    task automatic measure(input string req, input int exp);
        int found = -1;
        tick = 1'b1;
        for (int i = 1; i <= 700; i++) begin
            @(negedge clk);
            if (start_ok) begin
                found = i;
                break;
            end
        end
        tick = 1'b0;
        check(found == exp, req, found, exp);
        @(negedge clk);
        check(start_ok == 1'b0, "R9", int'(start_ok), 0);
    endtask

    task automatic pulse_evt(input int outcome, input int bitsel);
        evt     = EVT_W'(1) << bitsel;
        tx_won  = (outcome == 1);
        tx_lost = (outcome == 2);
        if (outcome != 0) mh = outcome;
        @(negedge clk);
        evt     = '0;
        tx_won  = 1'b0;
        tx_lost = 1'b0;
        settle(2);
    endtask

    initial begin
        int bad;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(start_ok == 1'b0, "R1", int'(start_ok), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_ok == 1'b0, "R1", int'(start_ok), 0);

        // Request-triggered counting
        auto_pre = 1'b0;
        enable   = 1'b1;
        settle(2);
        evt = 6'b000001;
        @(negedge clk);
        evt = '0;
        tick = 1'b1;
        bad = 0;
        repeat (400) begin
            @(negedge clk);
            if (start_ok) bad++;
        end
        tick = 1'b0;
        check(bad == 0, "R6", bad, 0);
        tx_req = 1'b1;
        #1;
        check(start_ok == 1'b0, "R6", int'(start_ok), 0);
        settle(2);
        measure("R6", exp_ticks(0, 0));

        // History-dependent windows
        pulse_evt(1, 0);
        measure("R4", exp_ticks(0, 1));
        pulse_evt(2, 1);
        measure("R5", exp_ticks(0, 2));
        pulse_evt(0, 2);
        measure("R5", exp_ticks(0, 2));

        // Fixed windows
        for (int k = 1; k <= 7; k++) begin
            sel_code = 3'(k);
            pulse_evt(0, k % EVT_W);
            measure("R2", exp_ticks(k, mh));
        end
        sel_code = 3'd0;

        // Disable resets history
        enable = 1'b0;
        mh = 0;
        @(negedge clk);
        check(start_ok == 1'b0, "R1", int'(start_ok), 0);
        enable = 1'b1;
        settle(2);
        measure("R10", exp_ticks(0, 0));
        measure_new_check: begin
            pulse_evt(0, 3);
            measure("R3", exp_ticks(0, 0));
        end

        // Line low during counting restarts the window
        pulse_evt(0, 4);
        tick = 1'b1;
        repeat (100) @(negedge clk);
        line_hi = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(start_ok == 1'b0, "R8", int'(start_ok), 0);
        end
        tick = 1'b0;
        line_hi = 1'b1;
        settle(1);
        measure("R8", exp_ticks(0, 0));

        // Pre-counted mode
        tx_req   = 1'b0;
        enable   = 1'b0;
        auto_pre = 1'b1;
        mh = 0;
        @(negedge clk);
        enable = 1'b1;
        settle(1);
        tick = 1'b1;
        bad = 0;
        repeat (exp_ticks(0, 0) + 5) begin
            @(negedge clk);
            if (start_ok) bad++;
        end
        tick = 1'b0;
        check(bad == 0, "R7", bad, 0);
        tx_req = 1'b1;
        #1;
        check(start_ok == 1'b1, "R7", int'(start_ok), 1);
        @(negedge clk);
        check(start_ok == 1'b0, "R9", int'(start_ok), 0);

        // Request waits while count runs
        pulse_evt(1, 5);
        measure("R7", exp_ticks(0, 1));

        // Second event mid-window restarts count
        pulse_evt(0, 0);
        tick = 1'b1;
        repeat (50) @(negedge clk);
        tick = 1'b0;
        pulse_evt(0, 2);
        measure("R7", exp_ticks(0, mh));

        // Random windows
        for (int it = 0; it < 16; it++) begin
            int s;
            int o;
            s = int'($urandom % 8);
            o = int'($urandom % 3);
            sel_code = 3'(s);
            pulse_evt(o, int'($urandom % EVT_W));
            measure(s == 0 ? (mh == 1 ? "R4" : (mh == 2 ? "R5" : "R3")) : "R2",
                    exp_ticks(s, mh));
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule